// File: doc/BRIEF.md
# Video RAM Serial Read Port

This block is a small dual-path video memory. A random port reads and writes single words of a row-by-column array. Beside it, a serial path can copy an entire row into a wide shadow register in one clock. That path then streams the row out one word at a time, starting at a chosen column.

A column counter selects the word through a multiplexer over the shadow register. Each serial clock pulse, when output is enabled, presents the selected word and moves the counter on by one. The counter returns to column zero after the last column of the row.

Once a row has been copied, the serial stream no longer depends on the array. The random port can therefore keep reading and writing while display data streams out. A new transfer may arrive in the middle of a stream: it replaces both the shadow row and the start column, and the next serial pulse delivers the first word of the new row.

Top module: `vram_serial_port`

## Requirements
- R1: A random-port cycle with `rp_en`=1 and `rp_we`=1 stores `rp_wdata` at row `rp_addr[RAW+CAW-1:CAW]`, column `rp_addr[CAW-1:0]`. A cycle with `rp_en`=1 and `rp_we`=0 places that location's word on `rp_rdata` one clock later. In every other cycle, `rp_rdata` holds its value.
- R2: A transfer (`xfer_req`=1) copies every column of row `xfer_row` into the shadow register in one clock. If a random write hits that row in the same clock, the shadow register takes the contents from before that write.
- R3: A transfer loads `xfer_col` into the column counter, and `ser_col` shows that value one clock later.
- R4: A serial step is a cycle with `ser_clk_en`=1, `ser_oe`=1 and `xfer_req`=0. In the clock after a step, `ser_dout` carries the shadow word at column `ser_col`, and `ser_col` has moved to the next column. Column 2^CAW-1 is followed by column 0.
- R5: With `ser_oe`=0, or with `ser_clk_en`=0, and no transfer, `ser_dout` and `ser_col` hold their values.
- R6: A transfer that coincides with a serial pulse takes priority: the step is dropped and `ser_dout` holds. The first word of the new row appears after the next serial step.
- R7: Random-port reads and writes after a transfer change neither the serial words nor `ser_col`.
- R8: After reset, `ser_dout`, `ser_col` and `rp_rdata` are 0. The shadow register is also cleared, so a serial step before any transfer outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| rp_en | input | 1 | Random-port access strobe |
| rp_we | input | 1 | Random-port write (1) or read (0) |
| rp_addr | input | RAW+CAW | Random-port address, row in the upper bits |
| rp_wdata | input | W | Random-port write word |
| rp_rdata | output | W | Random-port read word |
| xfer_req | input | 1 | Row-to-shadow transfer request |
| xfer_row | input | RAW | Row to copy |
| xfer_col | input | CAW | Serial start column |
| ser_clk_en | input | 1 | Serial clock pulse |
| ser_oe | input | 1 | Serial output enable |
| ser_dout | output | W | Serial output word |
| ser_col | output | CAW | Column of the next serial word |

## Verification
Every result of this block is due exactly one clock after its stimulus:
- the random read word;
- the loaded start column;
- the serial word together with the advanced column.

The bench drives each stimulus on a falling edge and compares the outputs at the next falling edge, after the single rising edge that registers them. Cases where two events meet in the same cycle are checked on their first visible clock:
- a transfer that coincides with a serial pulse, where `ser_dout` must hold and `ser_col` must show the new start;
- a transfer that coincides with a write to the copied row, where the first serial word after it must be the old value.

// File: rtl/vram_pkg.sv
package vram_pkg;

  // Column that follows col in a row of ncols columns (wraps to 0).
  function automatic int unsigned vr_col_after(input int unsigned col,
                                               input int unsigned ncols);
    return (col + 1 >= ncols) ? 0 : col + 1;
  endfunction

  // Lowest bit of a column's word inside a flattened row of w-bit words.
  function automatic int unsigned vr_word_lsb(input int unsigned col,
                                              input int unsigned w);
    return col * w;
  endfunction

endpackage

// File: rtl/vram_array.sv
module vram_array #(
  parameter int RAW = 4,
  parameter int CAW = 4,
  parameter int W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rp_en,
  input  logic                      rp_we,
  input  logic [RAW+CAW-1:0]        rp_addr,
  input  logic [W-1:0]              rp_wdata,
  output logic [W-1:0]              rp_rdata,
  input  logic [RAW-1:0]            row_sel,
  output logic [(1<<CAW)*W-1:0]     row_bits
);
  import vram_pkg::*;

  localparam int ROWS = 1 << RAW;
  localparam int COLS = 1 << CAW;
  localparam int RW   = COLS * W;

  logic [RW-1:0]  mem [ROWS];
  logic [RAW-1:0] a_row;
  logic [CAW-1:0] a_col;

  assign a_row = rp_addr[RAW+CAW-1:CAW];
  assign a_col = rp_addr[CAW-1:0];

  always_ff @(posedge clk) begin
    if (rp_en && rp_we)
      mem[a_row][vr_word_lsb(int'(a_col), W) +: W] <= rp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rp_rdata <= '0;
    else if (rp_en && !rp_we)
      rp_rdata <= mem[a_row][vr_word_lsb(int'(a_col), W) +: W];
  end

  // Whole selected row, read before any same-cycle write lands.
  assign row_bits = mem[row_sel];

endmodule

// File: rtl/vram_row_reg.sv
module vram_row_reg #(
  parameter int CAW = 4,
  parameter int W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [(1<<CAW)*W-1:0] row_in,
  output logic [(1<<CAW)*W-1:0] row_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_q <= '0;
    else if (load)
      row_q <= row_in;
  end
endmodule

// File: rtl/vram_col_counter.sv
module vram_col_counter #(
  parameter int CAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [CAW-1:0] load_col,
  input  logic           advance,
  output logic [CAW-1:0] col
);
  import vram_pkg::*;

  localparam int COLS = 1 << CAW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      col <= '0;
    else if (load)
      col <= load_col;
    else if (advance)
      col <= CAW'(vr_col_after(int'(col), COLS));
  end
endmodule

// File: rtl/vram_ser_mux.sv
module vram_ser_mux #(
  parameter int CAW = 4,
  parameter int W   = 4
) (
  input  logic [(1<<CAW)*W-1:0] row_q,
  input  logic [CAW-1:0]        sel,
  output logic [W-1:0]          word
);
  import vram_pkg::*;

  localparam int COLS = 1 << CAW;

  logic [W-1:0] slices [COLS];

  for (genvar g = 0; g < COLS; g++) begin : g_slice
    assign slices[g] = row_q[vr_word_lsb(g, W) +: W];
  end

  assign word = slices[sel];
endmodule

// File: rtl/vram_serial_port.sv
module vram_serial_port #(
  parameter int RAW = 4,
  parameter int CAW = 4,
  parameter int W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rp_en,
  input  logic               rp_we,
  input  logic [RAW+CAW-1:0] rp_addr,
  input  logic [W-1:0]       rp_wdata,
  output logic [W-1:0]       rp_rdata,
  input  logic               xfer_req,
  input  logic [RAW-1:0]     xfer_row,
  input  logic [CAW-1:0]     xfer_col,
  input  logic               ser_clk_en,
  input  logic               ser_oe,
  output logic [W-1:0]       ser_dout,
  output logic [CAW-1:0]     ser_col
);
  localparam int RW = (1 << CAW) * W;

  logic [RW-1:0] row_bits;
  logic [RW-1:0] shadow_q;
  logic [W-1:0]  sel_word;
  logic          step_fire;

  // A transfer takes priority over a serial pulse in the same cycle.
  assign step_fire = ser_clk_en && ser_oe && !xfer_req;

  vram_array #(.RAW(RAW), .CAW(CAW), .W(W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rp_en    (rp_en),
    .rp_we    (rp_we),
    .rp_addr  (rp_addr),
    .rp_wdata (rp_wdata),
    .rp_rdata (rp_rdata),
    .row_sel  (xfer_row),
    .row_bits (row_bits)
  );

  vram_row_reg #(.CAW(CAW), .W(W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (xfer_req),
    .row_in (row_bits),
    .row_q  (shadow_q)
  );

  vram_col_counter #(.CAW(CAW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (xfer_req),
    .load_col (xfer_col),
    .advance  (step_fire),
    .col      (ser_col)
  );

  vram_ser_mux #(.CAW(CAW), .W(W)) u_mux (
    .row_q (shadow_q),
    .sel   (ser_col),
    .word  (sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ser_dout <= '0;
    else if (step_fire)
      ser_dout <= sel_word;
  end

endmodule

// File: rtl/vram_serial_port_chk.sv
module vram_serial_port_chk #(
  parameter int CAW = 4,
  parameter int W   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rp_en,
  input logic           rp_we,
  input logic [W-1:0]   rp_rdata,
  input logic           xfer_req,
  input logic [CAW-1:0] xfer_col,
  input logic           ser_clk_en,
  input logic           ser_oe,
  input logic           step_fire,
  input logic [W-1:0]   sel_word,
  input logic [W-1:0]   ser_dout,
  input logic [CAW-1:0] ser_col
);
  import vram_pkg::*;

  localparam int COLS = 1 << CAW;

  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rp_en && !rp_we) |=> $stable(rp_rdata));

  a_r3_col_load: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> ser_col == $past(xfer_col));

  a_r4_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> ser_col == CAW'(vr_col_after(int'($past(ser_col)), COLS)));

  a_r4_word_out: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> ser_dout == $past(sel_word));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_req && !(ser_clk_en && ser_oe)) |=> ($stable(ser_col) && $stable(ser_dout)));

  a_r6_xfer_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && ser_clk_en && ser_oe) |=> $stable(ser_dout));

endmodule

bind vram_serial_port vram_serial_port_chk #(.CAW(CAW), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rp_en      (rp_en),
  .rp_we      (rp_we),
  .rp_rdata   (rp_rdata),
  .xfer_req   (xfer_req),
  .xfer_col   (xfer_col),
  .ser_clk_en (ser_clk_en),
  .ser_oe     (ser_oe),
  .step_fire  (step_fire),
  .sel_word   (sel_word),
  .ser_dout   (ser_dout),
  .ser_col    (ser_col)
);

// File: tb/vram_serial_port_bench.sv
module vram_serial_port_bench;
  localparam int RAW  = 4;
  localparam int CAW  = 4;
  localparam int W    = 4;
  localparam int ROWS = 1 << RAW;
  localparam int COLS = 1 << CAW;
  localparam int AW   = RAW + CAW;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           rp_en = 0, rp_we = 0;
  logic [AW-1:0]  rp_addr = '0;
  logic [W-1:0]   rp_wdata = '0;
  logic [W-1:0]   rp_rdata;
  logic           xfer_req = 0;
  logic [RAW-1:0] xfer_row = '0;
  logic [CAW-1:0] xfer_col = '0;
  logic           ser_clk_en = 0, ser_oe = 0;
  logic [W-1:0]   ser_dout;
  logic [CAW-1:0] ser_col;

  int tests = 0;
  int fails = 0;
  int mdl  [ROWS][COLS];
  int snap [COLS];

  always #10 clk = ~clk;

  vram_serial_port #(.RAW(RAW), .CAW(CAW), .W(W)) u_vram_serial_port (
    .clk(clk), .rst_n(rst_n), .rp_en(rp_en), .rp_we(rp_we), .rp_addr(rp_addr),
    .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .xfer_req(xfer_req),
    .xfer_row(xfer_row), .xfer_col(xfer_col), .ser_clk_en(ser_clk_en),
    .ser_oe(ser_oe), .ser_dout(ser_dout), .ser_col(ser_col)
  );

  function automatic int pat(input int r, input int c);
    return (r * 3 + c * 5 + 7) % (1 << W);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rp_en = 0; rp_we = 0; xfer_req = 0; ser_clk_en = 0; ser_oe = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_addr(input int r, input int c);
    rp_addr = AW'((r << CAW) | c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0, c0, s;
    idle();
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R8 reset state
    chk(ser_dout == 0, "R8 ser_dout", int'(ser_dout), 0);
    chk(ser_col == 0, "R8 ser_col", int'(ser_col), 0);
    chk(rp_rdata == 0, "R8 rp_rdata", int'(rp_rdata), 0);
    ser_clk_en = 1; ser_oe = 1; tick(); idle();
    chk(ser_dout == 0, "R8 cleared shadow", int'(ser_dout), 0);
    chk(ser_col == 1, "R4 first step", int'(ser_col), 1);

    // Fill array (R1)
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rp_en = 1; rp_we = 1; set_addr(r, c); rp_wdata = W'(pat(r, c));
        mdl[r][c] = pat(r, c);
        tick();
      end
    idle();

    // R1 read-back sweep
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rp_en = 1; rp_we = 0; set_addr(r, c);
        tick();
        chk(int'(rp_rdata) == mdl[r][c], "R1 read", int'(rp_rdata), mdl[r][c]);
      end
    idle(); tick();
    chk(int'(rp_rdata) == mdl[ROWS-1][COLS-1], "R1 idle hold", int'(rp_rdata), mdl[ROWS-1][COLS-1]);
    rp_en = 1; rp_we = 1; set_addr(0, 0); rp_wdata = W'(mdl[0][0] ^ 5);
    mdl[0][0] = mdl[0][0] ^ 5;
    tick(); idle();
    chk(int'(rp_rdata) == mdl[ROWS-1][COLS-1], "R1 write hold", int'(rp_rdata), mdl[ROWS-1][COLS-1]);

    // R3/R4/R7 row sweep with concurrent random traffic
    for (int r = 0; r < ROWS; r++) begin
      s = (r * 7 + 3) % COLS;
      xfer_req = 1; xfer_row = RAW'(r); xfer_col = CAW'(s);
      tick(); idle();
      chk(int'(ser_col) == s, "R3 start col", int'(ser_col), s);
      for (int c = 0; c < COLS; c++) snap[c] = mdl[r][c];
      for (int i = 0; i < COLS + 3; i++) begin
        int cc;
        cc = (s + i) % COLS;
        ser_clk_en = 1; ser_oe = 1;
        rp_en = 1; set_addr(r, cc);
        if (i % 2 == 1) begin
          rp_we = 1; rp_wdata = W'(mdl[r][cc] ^ 15);
          mdl[r][cc] = mdl[r][cc] ^ 15;
        end else begin
          rp_we = 0;
        end
        tick(); idle();
        chk(int'(ser_dout) == snap[cc], "R4 R7 serial word", int'(ser_dout), snap[cc]);
        chk(int'(ser_col) == (cc + 1) % COLS, "R4 col advance", int'(ser_col), (cc + 1) % COLS);
        if (i % 2 == 0)
          chk(int'(rp_rdata) == mdl[r][cc], "R1 R7 concurrent read", int'(rp_rdata), mdl[r][cc]);
      end
    end

    // R5 hold
    d0 = int'(ser_dout); c0 = int'(ser_col);
    ser_clk_en = 1; ser_oe = 0; repeat (3) tick(); idle();
    chk(int'(ser_dout) == d0, "R5 oe low dout", int'(ser_dout), d0);
    chk(int'(ser_col) == c0, "R5 oe low col", int'(ser_col), c0);
    ser_clk_en = 0; ser_oe = 1; repeat (2) tick(); idle();
    chk(int'(ser_dout) == d0, "R5 no pulse dout", int'(ser_dout), d0);
    chk(int'(ser_col) == c0, "R5 no pulse col", int'(ser_col), c0);

    // R2 same-cycle write to transferred row
    d0 = mdl[5][9];
    xfer_req = 1; xfer_row = 5; xfer_col = 9;
    rp_en = 1; rp_we = 1; set_addr(5, 9); rp_wdata = W'((d0 + 1) % (1 << W));
    mdl[5][9] = (d0 + 1) % (1 << W);
    tick(); idle();
    ser_clk_en = 1; ser_oe = 1; tick(); idle();
    chk(int'(ser_dout) == d0, "R2 old row copied", int'(ser_dout), d0);
    ser_clk_en = 1; ser_oe = 1; tick(); idle();
    chk(int'(ser_dout) == mdl[5][10], "R2 next word", int'(ser_dout), mdl[5][10]);

    // R6 transfer wins over a coincident serial pulse
    d0 = int'(ser_dout);
    xfer_req = 1; xfer_row = 12; xfer_col = 14; ser_clk_en = 1; ser_oe = 1;
    tick(); idle();
    chk(int'(ser_dout) == d0, "R6 dout held", int'(ser_dout), d0);
    chk(int'(ser_col) == 14, "R6 new start", int'(ser_col), 14);
    ser_clk_en = 1; ser_oe = 1; tick(); idle();
    chk(int'(ser_dout) == mdl[12][14], "R6 first new word", int'(ser_dout), mdl[12][14]);
    ser_clk_en = 1; ser_oe = 1; tick(); idle();
    chk(int'(ser_dout) == mdl[12][15], "R4 last column", int'(ser_dout), mdl[12][15]);
    chk(int'(ser_col) == 0, "R4 wrap", int'(ser_col), 0);
    ser_clk_en = 1; ser_oe = 1; tick(); idle();
    chk(int'(ser_dout) == mdl[12][0], "R4 after wrap", int'(ser_dout), mdl[12][0]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule